// File: doc/BRIEF.md
# Multichannel DAC Angle-Table Sequencer

This block sets 64 phase-shifter voltages held in four serial DAC devices, each device owning 16 channels. A host stream delivers entries that carry a mode bit, an angle index, a channel number and a 14-bit code. The entries wait in a small FIFO so that a burst is not lost. An entry in direct mode goes out at once as a single serial frame, followed by a load pulse. An entry in table mode is written into on-chip code storage, which holds one full 64-channel set for each steering angle.

An angle request replays a stored set. The four serial buses run side by side, and each bus sends its 16 channels in ascending address order. A single shared load strobe then makes all 64 outputs change together. The whole replay fits inside a 7.4 us budget at a 200 MHz system clock. The serial clock is the system clock divided by four (50 MHz). A host can therefore steer the beam with one request per angle, after it has loaded the table once.

Top module: `dac_angle_seq`

## Requirements
- R1: After reset, busy, done, all serial clocks and the load strobe are low, and all chip selects are high.
- R2: A FIFO entry with host_table=0 sends one frame on bus host_chan[5:4], and no other bus is active. The frame is 20 bits, most significant bit first: host_chan[3:0], then the 14-bit code, then two 0 bits. Chip select is low for exactly those 20 bit periods. Data changes while the serial clock is low and is sampled on its rising edge. The load strobe follows the frame.
- R3: A FIFO entry with host_table=1 stores the code for (host_angle, host_chan) and produces no serial traffic and no change in any output.
- R4: A request taken while idle sends, on all four buses in parallel, the 16 stored codes of sel_angle, with addresses 0 to 15 in ascending order. After a load pulse, every output holds the stored set of that angle.
- R5: busy stays high for exactly 1412 system clocks per replay: 352 bit periods plus one load bit period, at 4 clocks per bit. This is 7.06 us at 200 MHz, within the 7.4 us budget.
- R6: The load strobe is high for exactly one bit period (4 clocks), and only while every chip select is high.
- R7: done is high for exactly one clock, in the first clock in which busy is low after a replay, and is never raised by a direct-mode entry.
- R8: An angle request that arrives while busy is ignored: it starts no second replay and changes no output.
- R9: Entries are applied in arrival order. While a replay runs, the FIFO keeps up to 16 entries, and an entry offered while it is full is dropped.
- R10: Between consecutive frames on one bus, chip select stays high for exactly 2 bit periods (8 clocks), and data never changes while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 200 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| host_valid | input | 1 | Host entry strobe, one entry per clock |
| host_table | input | 1 | 1 = store into table, 0 = send directly |
| host_angle | input | 3 | Angle index for table-mode entries |
| host_chan | input | 6 | Channel: [5:4] device, [3:0] address on device |
| host_code | input | 14 | Channel code |
| sel_req | input | 1 | Angle replay request |
| sel_angle | input | 3 | Angle to replay |
| busy | output | 1 | Sequence in progress; requests are ignored |
| done | output | 1 | One-clock pulse at replay completion |
| spi_sclk | output | 4 | Serial clock, one per device |
| spi_csn | output | 4 | Chip select, active low, one per device |
| spi_mosi | output | 4 | Serial data, one per device |
| dac_load | output | 1 | Shared load strobe, active high |

## Verification
A wrong sequence counter or bit counter shows at the pins within the first frame. The bench decodes every frame from the serial pins and flags a wrong bit count, a nonzero pad or a wrong address order on the next rising edge of chip select. A wrong table address, or a wrong bank chosen by a host entry, leaves a wrong value in the decoded output copy, which is compared against a behavioural model at the next load. Errors in the busy, done and FIFO-drop timing show as a wrong busy length within one replay, or as a stale output once the FIFO has drained.

// File: rtl/dac_seq_pkg.sv
// Shared frame format and sequencer state for the DAC angle-table sequencer.
// Assumes the DAC devices take a 4-bit address, a 14-bit code and 2 pad bits.
package dac_seq_pkg;
    localparam int ADDR_W    = 4;
    localparam int CODE_W    = 14;
    localparam int PAD_W     = 2;
    localparam int GAP_BITS  = 2;
    localparam int FRAME_W   = ADDR_W + CODE_W + PAD_W;
    localparam int SLOT_BITS = FRAME_W + GAP_BITS;
    localparam int CH_PER_DEV = 2 ** ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/host_fifo.sv
// Synchronous first-word-fall-through FIFO for host entries.
// Assumes DEPTH is a power of two; writes while full are discarded,
// and the reader pops only when not empty.
module host_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rd_data = mem[rp[AW-1:0]];

    // Storage write for accepted entries.
    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
    end

    // Pointer advance on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_en && !full) wp <= wp + 1'b1;
            if (rd_en && !empty) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/code_bank.sv
// Code storage for one DAC device: one word per (angle, channel).
// Asynchronous read so a frame word is ready in the cycle its address is set.
module code_bank #(
    parameter int AW = 7,
    parameter int W  = 14
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [W-1:0] mem [DEPTH];

    // Table write from the host path.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_lane.sv
// Registered serial pins for one DAC device. The shared bit timer gives the
// bit index and clock phase; the lane turns them into clean SCLK/CS/MOSI.
// Assumes bit_idx < FRAME_W whenever active is high.
module spi_lane
    import dac_seq_pkg::*;
#(
    parameter int BIT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               sclk_hi,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic [FRAME_W-1:0] word,
    output logic               sclk,
    output logic               csn,
    output logic               mosi
);
    logic [BIT_W-1:0] sel;

    // Map bit index to word position, most significant bit first.
    always_comb begin
        sel = active ? (BIT_W'(FRAME_W - 1) - bit_idx) : '0;
    end

    // Register the pins so they carry no decode glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            csn  <= 1'b1;
            mosi <= 1'b0;
        end else begin
            sclk <= active & sclk_hi;
            csn  <= ~active;
            mosi <= active & word[sel];
        end
    end
endmodule

// File: rtl/dac_angle_seq.sv
// Multichannel DAC angle-table sequencer. Host entries pass through a FIFO
// and either go straight to one DAC as a single frame or land in the code
// table. An angle request replays a stored set on all buses in parallel,
// then pulses one shared load strobe. Assumes N_DEV >= 2, FIFO_DEPTH and
// N_ANGLE are powers of two, and CLK_DIV is even and at least 2.
module dac_angle_seq
    import dac_seq_pkg::*;
#(
    parameter int N_DEV      = 4,
    parameter int N_ANGLE    = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    host_valid,
    input  logic                                    host_table,
    input  logic [$clog2(N_ANGLE)-1:0]              host_angle,
    input  logic [$clog2(N_DEV)+dac_seq_pkg::ADDR_W-1:0] host_chan,
    input  logic [dac_seq_pkg::CODE_W-1:0]          host_code,
    input  logic                                    sel_req,
    input  logic [$clog2(N_ANGLE)-1:0]              sel_angle,
    output logic                                    busy,
    output logic                                    done,
    output logic [N_DEV-1:0]                        spi_sclk,
    output logic [N_DEV-1:0]                        spi_csn,
    output logic [N_DEV-1:0]                        spi_mosi,
    output logic                                    dac_load
);
    localparam int DEV_W   = $clog2(N_DEV);
    localparam int CHAN_W  = DEV_W + ADDR_W;
    localparam int ANG_W   = $clog2(N_ANGLE);
    localparam int ENTRY_W = 1 + ANG_W + CHAN_W + CODE_W;
    localparam int DIV_W   = $clog2(CLK_DIV);
    localparam int BIT_W   = $clog2(SLOT_BITS);
    localparam int BANK_AW = ANG_W + ADDR_W;

    seq_state_t         st;
    logic [DIV_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [ADDR_W-1:0]  frm_cnt;
    logic               replay_q;
    logic [ANG_W-1:0]   angle_q;
    logic [DEV_W-1:0]   dir_dev;
    logic [ADDR_W-1:0]  dir_ch;
    logic [CODE_W-1:0]  dir_code;

    logic [ENTRY_W-1:0] f_rdata;
    logic               f_empty;
    logic               f_full;
    logic               f_pop;
    logic               e_tbl;
    logic [ANG_W-1:0]   e_angle;
    logic [CHAN_W-1:0]  e_chan;
    logic [CODE_W-1:0]  e_code;
    logic               bit_end;
    logic               sclk_hi;
    logic               in_frame;

    logic [CODE_W-1:0]  bank_rd [N_DEV];

    host_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_valid),
        .wr_data ({host_table, host_angle, host_chan, host_code}),
        .rd_en   (f_pop),
        .rd_data (f_rdata),
        .empty   (f_empty),
        .full    (f_full)
    );

    // Unpack the entry at the FIFO head.
    always_comb begin
        e_code  = f_rdata[CODE_W-1:0];
        e_chan  = f_rdata[CODE_W +: CHAN_W];
        e_angle = f_rdata[CODE_W+CHAN_W +: ANG_W];
        e_tbl   = f_rdata[ENTRY_W-1];
    end

    // Head entries are taken only when idle and no angle request is present.
    assign f_pop    = (st == ST_IDLE) && !sel_req && !f_empty;
    assign bit_end  = (div_cnt == DIV_W'(CLK_DIV - 1));
    assign sclk_hi  = (div_cnt >= DIV_W'(CLK_DIV / 2));
    assign in_frame = (st == ST_SHIFT) && (bit_cnt < BIT_W'(FRAME_W));
    assign busy     = (st != ST_IDLE);

    // Sequencer: accepts work when idle, times bits, frames and the load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            frm_cnt  <= '0;
            replay_q <= 1'b0;
            angle_q  <= '0;
            dir_dev  <= '0;
            dir_ch   <= '0;
            dir_code <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    frm_cnt <= '0;
                    if (sel_req) begin
                        st       <= ST_SHIFT;
                        replay_q <= 1'b1;
                        angle_q  <= sel_angle;
                    end else if (f_pop && !e_tbl) begin
                        st       <= ST_SHIFT;
                        replay_q <= 1'b0;
                        dir_dev  <= e_chan[CHAN_W-1:ADDR_W];
                        dir_ch   <= e_chan[ADDR_W-1:0];
                        dir_code <= e_code;
                    end
                end
                ST_SHIFT: begin
                    div_cnt <= bit_end ? '0 : div_cnt + 1'b1;
                    if (bit_end) begin
                        if (bit_cnt == BIT_W'(SLOT_BITS - 1)) begin
                            bit_cnt <= '0;
                            if (!replay_q || frm_cnt == '1) st <= ST_LOAD;
                            else                             frm_cnt <= frm_cnt + 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    div_cnt <= bit_end ? '0 : div_cnt + 1'b1;
                    if (bit_end) begin
                        st   <= ST_IDLE;
                        done <= replay_q;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Shared load strobe, registered to line up with the lane pins.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_load <= 1'b0;
        else        dac_load <= (st == ST_LOAD);
    end

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        logic               lane_act;
        logic               bank_we;
        logic [FRAME_W-1:0] lane_word;

        assign bank_we  = f_pop && e_tbl && (e_chan[CHAN_W-1:ADDR_W] == DEV_W'(d));
        assign lane_act = in_frame && (replay_q || dir_dev == DEV_W'(d));

        // Frame word: table code during replay, latched host code otherwise.
        always_comb begin
            if (replay_q) lane_word = {frm_cnt, bank_rd[d], {PAD_W{1'b0}}};
            else          lane_word = {dir_ch, dir_code, {PAD_W{1'b0}}};
        end

        code_bank #(.AW(BANK_AW), .W(CODE_W)) u_bank (
            .clk   (clk),
            .we    (bank_we),
            .waddr ({e_angle, e_chan[ADDR_W-1:0]}),
            .wdata (e_code),
            .raddr ({angle_q, frm_cnt}),
            .rdata (bank_rd[d])
        );

        spi_lane #(.BIT_W(BIT_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (lane_act),
            .sclk_hi (sclk_hi),
            .bit_idx (bit_cnt),
            .word    (lane_word),
            .sclk    (spi_sclk[d]),
            .csn     (spi_csn[d]),
            .mosi    (spi_mosi[d])
        );
    end
endmodule

// File: rtl/dac_angle_seq_chk.sv
// Port-level protocol checker for the DAC angle-table sequencer, bound to
// every instance of the top. Window lengths are measured with counters.
module dac_angle_seq_chk
    import dac_seq_pkg::*;
#(
    parameter int N_DEV   = 4,
    parameter int CLK_DIV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [N_DEV-1:0] spi_sclk,
    input logic [N_DEV-1:0] spi_csn,
    input logic [N_DEV-1:0] spi_mosi,
    input logic             dac_load
);
    localparam int BUSY_MAX = CH_PER_DEV * SLOT_BITS * CLK_DIV + CLK_DIV;

    logic [7:0]  ld_len;
    logic [15:0] busy_run;

    // Length of the current load pulse and of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_len   <= '0;
            busy_run <= '0;
        end else begin
            ld_len   <= dac_load ? ld_len + 1'b1 : '0;
            busy_run <= busy ? busy_run + 1'b1 : '0;
        end
    end

    AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_load) |-> (ld_len == 8'(CLK_DIV))); // R6
    AST_LOAD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> (&spi_csn)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((spi_sclk & $past(spi_sclk) & (spi_mosi ^ $past(spi_mosi))) == '0)); // R10
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(BUSY_MAX)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (&spi_csn)); // R4
endmodule

bind dac_angle_seq dac_angle_seq_chk #(.N_DEV(N_DEV), .CLK_DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .spi_sclk (spi_sclk),
    .spi_csn  (spi_csn),
    .spi_mosi (spi_mosi),
    .dac_load (dac_load)
);

// File: tb/dac_angle_seq_test.sv
// Bench: drives host entries and angle requests, decodes every serial frame
// into a behavioural DAC model, and compares outputs against expected sets.
`timescale 1ns/100ps
module dac_angle_seq_test;
    localparam real CLK_PERIOD = 5.0;
    localparam int  NDEV = 4;
    localparam int  NANG = 8;
    localparam int  DIV  = 4;
    localparam int  REPLAY_CYC = 16 * 22 * DIV + DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_table = 1'b0;
    logic [2:0]  host_angle = '0;
    logic [5:0]  host_chan = '0;
    logic [13:0] host_code = '0;
    logic        sel_req = 1'b0;
    logic [2:0]  sel_angle = '0;
    logic        busy, done, dac_load;
    logic [3:0]  spi_sclk, spi_csn, spi_mosi;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int tab     [NANG][64];
    int exp_out [64];
    int in_reg  [64];
    int out_reg [64];
    int sh      [NDEV];
    int nb      [NDEV];
    int hi_cnt  [NDEV];
    int nfr     [NDEV];
    int ord_idx [NDEV];
    int ord_err [NDEV];
    int ld_w = 0;
    int done_cnt = 0;
    logic [3:0] p_sclk = '0;
    logic [3:0] p_csn  = '1;
    logic       p_load = 1'b0;

    dac_angle_seq uut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_table(host_table), .host_angle(host_angle),
        .host_chan(host_chan), .host_code(host_code),
        .sel_req(sel_req), .sel_angle(sel_angle), .busy(busy), .done(done),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .dac_load(dac_load)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Behavioural DAC model fed from the pins, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            for (int l = 0; l < NDEV; l++) begin
                if (spi_sclk[l] && !p_sclk[l] && !spi_csn[l]) begin
                    sh[l] = (sh[l] << 1) | int'(spi_mosi[l]);
                    nb[l]++;
                end
                if (spi_csn[l] && !p_csn[l]) begin
                    int addr;
                    check(nb[l] == 20, "R2 frame bits", nb[l], 20);
                    check((sh[l] & 3) == 0, "R2 pad bits", sh[l] & 3, 0);
                    addr = (sh[l] >> 16) & 15;
                    in_reg[l * 16 + addr] = (sh[l] >> 2) & 16'h3FFF;
                    if (addr != (ord_idx[l] % 16)) ord_err[l]++;
                    ord_idx[l]++;
                    nfr[l]++;
                end
                if (!spi_csn[l] && p_csn[l]) begin
                    if (hi_cnt[l] > 0 && hi_cnt[l] < 12)
                        check(hi_cnt[l] == 2 * DIV, "R10 gap", hi_cnt[l], 2 * DIV);
                    nb[l] = 0;
                    sh[l] = 0;
                end
                if (spi_csn[l]) hi_cnt[l]++;
                else            hi_cnt[l] = 0;
            end
            if (dac_load && !p_load) begin
                check(spi_csn == 4'hF, "R6 load with cs high", int'(spi_csn), 15);
                ld_w = 0;
            end
            if (dac_load) ld_w++;
            if (!dac_load && p_load) begin
                check(ld_w == DIV, "R6 load width", ld_w, DIV);
                for (int c = 0; c < 64; c++) out_reg[c] = in_reg[c];
            end
            p_sclk = spi_sclk;
            p_csn  = spi_csn;
            p_load = dac_load;
        end
    end

    task automatic host_put(input bit tbl, input int ang, input int ch, input int code);
        host_valid = 1'b1;
        host_table = tbl;
        host_angle = 3'(ang);
        host_chan  = 6'(ch);
        host_code  = 14'(code);
        @(negedge clk);
    endtask

    task automatic host_end();
        host_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            if (busy) q = 0;
            else      q++;
        end
    endtask

    task automatic compare_out(input string req);
        int bad = -1;
        for (int c = 0; c < 64; c++)
            if (bad < 0 && out_reg[c] != exp_out[c]) bad = c;
        if (bad < 0) check(1'b1, req, 0, 0);
        else         check(1'b0, req, out_reg[bad], exp_out[bad]);
    endtask

    function automatic int tcode(input int a, input int c);
        return (a * 977 + c * 131 + 5) & 16'h3FFF;
    endfunction

    task automatic start_req(input int ang);
        for (int l = 0; l < NDEV; l++) begin
            ord_idx[l] = 0;
            ord_err[l] = 0;
        end
        sel_req   = 1'b1;
        sel_angle = 3'(ang);
        @(negedge clk);
        sel_req = 1'b0;
    endtask

    // Plain replay: measures busy and done, checks order and outputs.
    task automatic replay(input int ang, input string req);
        int bcyc = 0;
        start_req(ang);
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
        check(bcyc == REPLAY_CYC, "R5 busy length", bcyc, REPLAY_CYC);
        check(real'(bcyc) * CLK_PERIOD <= 7400.0, "R5 time budget", bcyc, 1480);
        check(done == 1'b1, "R7 done at end", int'(done), 1);
        for (int l = 0; l < NDEV; l++) begin
            check(ord_idx[l] == 16, "R4 frames per bus", ord_idx[l], 16);
            check(ord_err[l] == 0, "R4 address order", ord_err[l], 0);
        end
        for (int c = 0; c < 64; c++) exp_out[c] = tab[ang][c];
        wait_quiet();
        compare_out(req);
    endtask

    initial begin
        int f0 [NDEV];
        int d0;
        for (int c = 0; c < 64; c++) begin
            exp_out[c] = 0; in_reg[c] = 0; out_reg[c] = 0;
            for (int a = 0; a < NANG; a++) tab[a][c] = 0;
        end
        for (int l = 0; l < NDEV; l++) begin
            sh[l] = 0; nb[l] = 0; hi_cnt[l] = 100; nfr[l] = 0; ord_idx[l] = 0; ord_err[l] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(spi_csn == 4'hF, "R1 csn", int'(spi_csn), 15);
        check(spi_sclk == 4'h0, "R1 sclk", int'(spi_sclk), 0);
        check(dac_load == 1'b0, "R1 load", int'(dac_load), 0);

        // R2 single direct write to device 0 channel 5
        for (int l = 0; l < NDEV; l++) f0[l] = nfr[l];
        d0 = done_cnt;
        host_put(1'b0, 0, 5, 14'h1234);
        host_end();
        wait_quiet();
        exp_out[5] = 14'h1234;
        compare_out("R2 direct value");
        check(nfr[0] - f0[0] == 1, "R2 frame on bus 0", nfr[0] - f0[0], 1);
        check(nfr[1] + nfr[2] + nfr[3] == f0[1] + f0[2] + f0[3], "R2 other buses quiet",
              nfr[1] + nfr[2] + nfr[3], f0[1] + f0[2] + f0[3]);
        check(done_cnt == d0, "R7 no done on direct", done_cnt, d0);

        // R9 back-to-back burst, applied in order (channel 17 written twice)
        host_put(1'b0, 0, 17, 14'h3FFF);
        host_put(1'b0, 0, 38, 0);
        host_put(1'b0, 0, 63, 14'h2AAA);
        host_put(1'b0, 0, 17, 14'h0F0F);
        host_put(1'b0, 0, 0, 14'h1555);
        host_end();
        wait_quiet();
        exp_out[17] = 14'h0F0F; exp_out[38] = 0; exp_out[63] = 14'h2AAA; exp_out[0] = 14'h1555;
        compare_out("R9 burst order");

        // R3 table fill produces no traffic and no output change
        for (int l = 0; l < NDEV; l++) f0[l] = nfr[l];
        for (int a = 0; a < NANG; a++)
            for (int c = 0; c < 64; c++) begin
                tab[a][c] = tcode(a, c);
                if (a == 7 && c == 0) tab[a][c] = 14'h3FFF;
                if (a == 0 && c == 63) tab[a][c] = 0;
                host_put(1'b1, a, c, tab[a][c]);
            end
        host_end();
        wait_quiet();
        check(nfr[0] + nfr[1] + nfr[2] + nfr[3] == f0[0] + f0[1] + f0[2] + f0[3],
              "R3 no frames", nfr[0] + nfr[1] + nfr[2] + nfr[3], f0[0] + f0[1] + f0[2] + f0[3]);
        compare_out("R3 outputs unchanged");

        // R4 replays, including the first and last angle
        d0 = done_cnt;
        replay(2, "R4 replay angle 2");
        replay(7, "R4 replay angle 7");
        replay(0, "R4 replay angle 0");
        check(done_cnt - d0 == 3, "R7 one done per replay", done_cnt - d0, 3);

        // R8 request during busy is ignored
        d0 = done_cnt;
        start_req(3);
        repeat (100) @(negedge clk);
        sel_req = 1'b1; sel_angle = 3'd5;
        @(negedge clk);
        sel_req = 1'b0;
        while (busy) @(negedge clk);
        for (int c = 0; c < 64; c++) exp_out[c] = tab[3][c];
        repeat (60) begin
            @(negedge clk);
        end
        check(busy == 1'b0, "R8 no second replay", int'(busy), 0);
        check(done_cnt - d0 == 1, "R8 single done", done_cnt - d0, 1);
        compare_out("R8 outputs from first angle");

        // R9 FIFO holds 16 entries during a replay and drops the rest
        start_req(1);
        begin
            int k = 0;
            while (busy) begin
                if (k >= 10 && k < 30) begin
                    host_valid = 1'b1; host_table = 1'b0;
                    host_chan = 6'(40 + k - 10); host_code = 14'(16'h0200 + k);
                end else begin
                    host_valid = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        host_end();
        for (int c = 0; c < 64; c++) exp_out[c] = tab[1][c];
        for (int j = 0; j < 16; j++) exp_out[40 + j] = 16'h0200 + 10 + j;
        wait_quiet();
        compare_out("R9 overflow drop");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule